// File: doc/BRIEF.md
# Two-Speed Clock Start-Up Controller

This block chooses the source of the system clock whenever the chip powers up or wakes from sleep. It lets the core run at once from a slow on-chip RC clock. Meanwhile, a counter in the primary crystal domain waits for a fixed number of primary cycles so the crystal has time to settle. Once that wait is over, the block raises a start-up status flag on a falling edge of the RC clock. It then keeps the system clock low for a set number of primary falling edges and hands the clock over to the primary oscillator. No shortened pulse can appear at any point.

A sleep request stops the sequence at any point. It also clears the status flag and halts the system clock. A later wake event starts a new sequence, and the counter begins again from zero. Software can move the clock-select field away from the primary setting, and the core then stays on the RC clock without waiting for the crystal. The two-speed feature is active only for crystal-type primary modes when its configuration bit is set. In every other case the block skips the count and the RC phase and goes straight to the primary oscillator.

Top module: `tsu_clock_starter`

## Requirements
- R1: While reset is asserted, and after reset until a start event arrives, `pri_stable` is 0 and `sys_clk` is held low. Reset also returns the registered clock-select copy to 00.
- R2: A pulse on `por_evt` or `wake_evt` while the block is stopped starts a sequence. With the feature active, `sys_clk` follows `irc_clk` within two RC cycles.
- R3: The feature is active only when `tsu_enable` is 1 and `pri_mode` is one of the crystal codes 3'b000, 3'b001 or 3'b010. Any other code counts as a non-crystal source.
- R4: With the feature active and a select of 00, `pri_stable` stays 0 until the start-up counter has seen `OST_CYCLES` (default 1024) rising edges of `pri_clk` since the start. It rises within a bounded synchronizer latency after that.
- R5: `pri_stable` is set only on a falling edge of `irc_clk`, and the RC clock gate closes on that same edge.
- R6: After `pri_stable` rises, `sys_clk` stays low across `HOLD_EDGES` (default 8) further falling edges of the synchronized primary clock. From then on it follows `pri_clk` cycle for cycle.
- R7: The RC and primary gates are never open together, and every high or low phase of `sys_clk` lasts at least half a period of the faster source clock.
- R8: A sleep request in any phase clears `pri_stable` and stops `sys_clk`. A sequence cut short this way never sets the flag, and the next start counts the full `OST_CYCLES` again from zero.
- R9: While the registered select is nonzero, `sys_clk` runs from `irc_clk` and `pri_stable` is held at 0. After the select returns to 00 with the count already expired, the flag sets within a few RC cycles.
- R10: With the feature inactive, a start runs no count and no RC phase. `sys_clk` stays low, `pri_stable` sets within a few RC cycles, and the handover of R6 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irc_clk | input | 1 | Slow internal RC clock |
| pri_clk | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_evt | input | 1 | Power-on-ready pulse, synchronous to irc_clk |
| wake_evt | input | 1 | Wake-from-sleep pulse, synchronous to irc_clk |
| sleep_req | input | 1 | Sleep entry pulse, synchronous to irc_clk |
| tsu_enable | input | 1 | Configuration bit enabling two-speed start-up |
| pri_mode | input | 3 | Primary oscillator mode code |
| sw_clk_sel | input | SEL_W | Software clock-select field (00 = primary) |
| sys_clk | output | 1 | Gated system clock |
| pri_stable | output | 1 | Primary oscillator start-up status flag |

## Verification
The bench first measures how many primary cycles pass between a start event and the status flag. A counter that stops early, or whose expiry crosses domains without synchronization, would raise the flag before 1024 cycles. It then counts primary falling edges from the flag to the first primary-driven clock edge. A design that switches at once, or one that leaves the RC gate open, would show edges inside that window. Sleep is requested in the middle of a count and again while the primary clock is running, and a restart follows right after. A design that keeps a stale expiry would set the flag after too few cycles. The nonzero-select and inactive-feature paths are driven as well, together with a running check on the minimum pulse width, which would catch any runt pulse at the handover.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
package tsu_pkg;

   typedef enum logic [1:0] {
      SEQ_STOP = 2'd0,
      SEQ_ARM  = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_t;

   localparam logic [2:0] PMODE_LOWPWR_XTAL = 3'd0;
   localparam logic [2:0] PMODE_STD_XTAL    = 3'd1;
   localparam logic [2:0] PMODE_FAST_XTAL   = 3'd2;

   function automatic logic mode_needs_settle(input logic [2:0] m);
      return (m == PMODE_LOWPWR_XTAL) || (m == PMODE_STD_XTAL) ||
             (m == PMODE_FAST_XTAL);
   endfunction

endpackage

// File: rtl/tsu_sync.sv
`timescale 1ns/1ps
module tsu_sync #(
   parameter int STAGES  = 2,
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tsu_sync: STAGES must be at least 2");
      end
      if (FALLING) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tsu_ost.sv
`timescale 1ns/1ps
module tsu_ost #(
   parameter  int CYCLES = 1024,
   localparam int CW     = $clog2(CYCLES + 1)
) (
   input  logic          pri_clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          expired,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

   logic [CW-1:0] cnt_next;

   always_comb begin
      if (!run)                cnt_next = '0;
      else if (count == LIMIT) cnt_next = count;
      else                     cnt_next = count + 1'b1;
   end

   // expiry is a flop output so the crossing sees a single clean bit
   always_ff @(posedge pri_clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         expired <= 1'b0;
      end else begin
         count   <= cnt_next;
         expired <= run && (cnt_next == LIMIT);
      end
   end

endmodule

// File: rtl/tsu_seq.sv
`timescale 1ns/1ps
module tsu_seq
   import tsu_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             irc_clk,
   input  logic             rst_n,
   input  logic             por_evt,
   input  logic             wake_evt,
   input  logic             sleep_req,
   input  logic             feat_on,
   input  logic [SEL_W-1:0] sw_sel,
   input  logic             exp_s,
   input  logic             pri_on_s,
   output seq_state_t       state,
   output logic [SEL_W-1:0] sel_q,
   output logic             ost_run,
   output logic             stable,
   output logic             irc_en
);

   logic sel_primary;
   logic active;
   logic stable_d;
   logic irc_en_d;

   always_ff @(posedge irc_clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_STOP;
         sel_q <= '0;
      end else begin
         sel_q <= sw_sel;
         unique case (state)
            SEQ_STOP: if (por_evt || wake_evt) state <= SEQ_ARM;
            SEQ_ARM: begin
               // wait until the previous run has fully drained in both domains
               if (sleep_req)                  state <= SEQ_STOP;
               else if (!exp_s && !pri_on_s)   state <= SEQ_RUN;
            end
            SEQ_RUN:  if (sleep_req) state <= SEQ_STOP;
            default:  state <= SEQ_STOP;
         endcase
      end
   end

   assign sel_primary = (sel_q == '0);
   assign active      = (state != SEQ_STOP);
   assign ost_run     = (state == SEQ_RUN) && feat_on;

   always_comb begin
      stable_d = (state == SEQ_RUN) &&
                 (stable || (sel_primary && (exp_s || !feat_on)));
      irc_en_d = active && !pri_on_s && !stable_d &&
                 (feat_on || !sel_primary);
   end

   // falling-edge registers: the RC gate only changes while irc_clk is low
   always_ff @(negedge irc_clk or negedge rst_n) begin
      if (!rst_n) begin
         stable <= 1'b0;
         irc_en <= 1'b0;
      end else begin
         stable <= stable_d;
         irc_en <= irc_en_d;
      end
   end

endmodule

// File: rtl/tsu_handover.sv
`timescale 1ns/1ps
module tsu_handover #(
   parameter  int HOLD = 8,
   localparam int HW   = $clog2(HOLD + 1)
) (
   input  logic pri_clk,
   input  logic rst_n,
   input  logic go,
   output logic pri_en
);

   localparam logic [HW-1:0] HOLD_LIM = HW'(HOLD);

   logic [HW-1:0] hold_cnt;

   always_ff @(negedge pri_clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         pri_en   <= 1'b0;
      end else if (!go) begin
         hold_cnt <= '0;
         pri_en   <= 1'b0;
      end else begin
         if (hold_cnt != HOLD_LIM) hold_cnt <= hold_cnt + 1'b1;
         pri_en <= (hold_cnt == HOLD_LIM);
      end
   end

endmodule

// File: rtl/tsu_clock_starter.sv
`timescale 1ns/1ps
module tsu_clock_starter
   import tsu_pkg::*;
#(
   parameter int OST_CYCLES  = 1024,
   parameter int HOLD_EDGES  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 2
) (
   input  logic             irc_clk,
   input  logic             pri_clk,
   input  logic             rst_n,
   input  logic             por_evt,
   input  logic             wake_evt,
   input  logic             sleep_req,
   input  logic             tsu_enable,
   input  logic [2:0]       pri_mode,
   input  logic [SEL_W-1:0] sw_clk_sel,
   output logic             sys_clk,
   output logic             pri_stable
);

   localparam int OST_W = $clog2(OST_CYCLES + 1);

   generate
      if (OST_CYCLES < 2) begin : g_bad_ost
         $error("tsu_clock_starter: OST_CYCLES must be at least 2");
      end
      if (HOLD_EDGES < 1) begin : g_bad_hold
         $error("tsu_clock_starter: HOLD_EDGES must be at least 1");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("tsu_clock_starter: SEL_W must be at least 1");
      end
   endgenerate

   seq_state_t       seq_state;
   logic [SEL_W-1:0] sel_q;
   logic             feat_on;
   logic             seq_active;
   logic             ost_run;
   logic             run_p;
   logic             ost_exp;
   logic             exp_s;
   logic             stable_p;
   logic             pri_en;
   logic             pri_on_s;
   logic             irc_en;
   logic [OST_W-1:0] ost_count;

   assign feat_on    = tsu_enable && mode_needs_settle(pri_mode);
   assign seq_active = (seq_state != SEQ_STOP);

   tsu_seq #(.SEL_W(SEL_W)) u_seq (
      .irc_clk   (irc_clk),
      .rst_n     (rst_n),
      .por_evt   (por_evt),
      .wake_evt  (wake_evt),
      .sleep_req (sleep_req),
      .feat_on   (feat_on),
      .sw_sel    (sw_clk_sel),
      .exp_s     (exp_s),
      .pri_on_s  (pri_on_s),
      .state     (seq_state),
      .sel_q     (sel_q),
      .ost_run   (ost_run),
      .stable    (pri_stable),
      .irc_en    (irc_en)
   );

   // RC -> primary: counter enable
   tsu_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_sync_run (
      .clk (pri_clk), .rst_n (rst_n), .d (ost_run), .q (run_p)
   );

   tsu_ost #(.CYCLES(OST_CYCLES)) u_ost (
      .pri_clk (pri_clk),
      .rst_n   (rst_n),
      .run     (run_p),
      .expired (ost_exp),
      .count   (ost_count)
   );

   // primary -> RC: terminal count
   tsu_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_sync_exp (
      .clk (irc_clk), .rst_n (rst_n), .d (ost_exp), .q (exp_s)
   );

   // RC -> primary falling-edge domain: status flag
   tsu_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_sync_stable (
      .clk (pri_clk), .rst_n (rst_n), .d (pri_stable), .q (stable_p)
   );

   tsu_handover #(.HOLD(HOLD_EDGES)) u_hand (
      .pri_clk (pri_clk),
      .rst_n   (rst_n),
      .go      (stable_p),
      .pri_en  (pri_en)
   );

   // primary gate state back to RC domain for break-before-make
   tsu_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_sync_pon (
      .clk (irc_clk), .rst_n (rst_n), .d (pri_en), .q (pri_on_s)
   );

   // each enable changes only while its own clock is low
   assign sys_clk = (irc_clk & irc_en) | (pri_clk & pri_en);

endmodule

// File: rtl/tsu_checker.sv
`timescale 1ns/1ps
module tsu_checker #(
   parameter  int OST_CYCLES = 1024,
   parameter  int SEL_W      = 2,
   localparam int OST_W      = $clog2(OST_CYCLES + 1)
) (
   input logic             irc_clk,
   input logic             pri_clk,
   input logic             rst_n,
   input logic             feat_on,
   input logic             exp_s,
   input logic             pri_stable,
   input logic             irc_en,
   input logic             pri_en,
   input logic             stable_p,
   input logic             seq_active,
   input logic [SEL_W-1:0] sel_q,
   input logic [OST_W-1:0] ost_count
);

   // R7: gates never open together
   a_r7_break_before_make: assert property (
      @(posedge pri_clk) disable iff (!rst_n) !(irc_en && pri_en));

   // R4 / R5: flag rises only on expiry seen at the previous falling RC edge
   a_r4_stable_after_expiry: assert property (
      @(negedge irc_clk) disable iff (!rst_n)
      $rose(pri_stable) |-> ($past(exp_s) || !feat_on));

   // R4: counter saturates at its limit
   a_r4_count_bounded: assert property (
      @(posedge pri_clk) disable iff (!rst_n) int'(ost_count) <= OST_CYCLES);

   // R8: a stopped sequence leaves the flag clear
   a_r8_stop_clears_flag: assert property (
      @(negedge irc_clk) disable iff (!rst_n)
      !$past(seq_active) |-> !pri_stable);

   // R6: primary gate opens only after the synchronized flag was present
   a_r6_gate_follows_flag: assert property (
      @(negedge pri_clk) disable iff (!rst_n)
      $rose(pri_en) |-> $past(stable_p));

   // R10 / R9: RC gate only for an active feature or a non-primary select
   a_r10_rc_gate_reason: assert property (
      @(negedge irc_clk) disable iff (!rst_n)
      irc_en |-> (feat_on || ($past(sel_q) != '0)));

endmodule

bind tsu_clock_starter tsu_checker #(
   .OST_CYCLES (OST_CYCLES),
   .SEL_W      (SEL_W)
) u_chk (
   .irc_clk    (irc_clk),
   .pri_clk    (pri_clk),
   .rst_n      (rst_n),
   .feat_on    (feat_on),
   .exp_s      (exp_s),
   .pri_stable (pri_stable),
   .irc_en     (irc_en),
   .pri_en     (pri_en),
   .stable_p   (stable_p),
   .seq_active (seq_active),
   .sel_q      (sel_q),
   .ost_count  (ost_count)
);

// File: tb/tb_tsu_clock_starter.sv
`timescale 1ns/1ps
module tb_tsu_clock_starter;

   logic       irc_clk = 1'b0;
   logic       pri_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_evt = 1'b0;
   logic       wake_evt = 1'b0;
   logic       sleep_req = 1'b0;
   logic       tsu_enable = 1'b1;
   logic [2:0] pri_mode = 3'd1;
   logic [1:0] sw_clk_sel = 2'b00;
   logic       sys_clk;
   logic       pri_stable;

   always #4  pri_clk = ~pri_clk;   // 125 MHz
   always #26 irc_clk = ~irc_clk;   // slow RC

   tsu_clock_starter dut (
      .irc_clk    (irc_clk),
      .pri_clk    (pri_clk),
      .rst_n      (rst_n),
      .por_evt    (por_evt),
      .wake_evt   (wake_evt),
      .sleep_req  (sleep_req),
      .tsu_enable (tsu_enable),
      .pri_mode   (pri_mode),
      .sw_clk_sel (sw_clk_sel),
      .sys_clk    (sys_clk),
      .pri_stable (pri_stable)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   int pri_cnt = 0;
   int sys_cnt = 0;
   realtime t_rise = 0.0, t_fall = 0.0;
   int min_high_ps = 1000000;
   int min_low_ps  = 1000000;

   always @(posedge pri_clk) pri_cnt++;
   always @(posedge sys_clk) begin
      sys_cnt++;
      if (t_fall > 0.0 && int'(($realtime - t_fall) * 1000.0) < min_low_ps)
         min_low_ps = int'(($realtime - t_fall) * 1000.0);
      t_rise = $realtime;
   end
   always @(negedge sys_clk) begin
      if (t_rise > 0.0 && int'(($realtime - t_rise) * 1000.0) < min_high_ps)
         min_high_ps = int'(($realtime - t_rise) * 1000.0);
      t_fall = $realtime;
   end

   // scoreboard
   typedef struct {
      string req;
      int    lo;
      int    hi;
   } exp_t;
   exp_t exp_q[$];
   int   act_q[$];

   task automatic expect_in(string req, int lo, int hi, int actual);
      exp_q.push_back('{req, lo, hi});
      act_q.push_back(actual);
   endtask

   initial begin
      forever begin
         wait (act_q.size() > 0);
         begin
            exp_t e;
            int   a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_checks++;
            if (a < e.lo || a > e.hi) begin
               n_fail++;
               $display("FAIL %s: actual %0d expected %0d..%0d", e.req, a, e.lo, e.hi);
            end
         end
      end
   end

   task automatic irc_cycles(int n);
      repeat (n) @(negedge irc_clk);
   endtask

   task automatic pulse(ref logic sig);
      @(negedge irc_clk);
      sig = 1'b1;
      @(negedge irc_clk);
      sig = 1'b0;
   endtask

   task automatic wait_stable(int limit);
      int n = 0;
      while (!pri_stable && n < limit) begin
         @(posedge pri_clk);
         n++;
      end
   endtask

   task automatic check_full_count(string req);
      int p0;
      @(negedge irc_clk);
      wake_evt = 1'b1;
      p0 = pri_cnt;
      @(negedge irc_clk);
      wake_evt = 1'b0;
      wait_stable(4000);
      expect_in(req, 1024, 1100, pri_cnt - p0);
   endtask

   task automatic check_bypass(string req);
      int p0, s0;
      s0 = sys_cnt;
      @(negedge irc_clk);
      wake_evt = 1'b1;
      p0 = pri_cnt;
      @(negedge irc_clk);
      wake_evt = 1'b0;
      wait_stable(4000);
      expect_in({req, " flag latency"}, 0, 60, pri_cnt - p0);
      expect_in({req, " no RC clocking"}, 0, 0, sys_cnt - s0);
      irc_cycles(30);
      s0 = sys_cnt;
      repeat (100) @(posedge pri_clk);
      expect_in({req, " runs on primary"}, 99, 101, sys_cnt - s0);
   endtask

   task automatic go_sleep();
      pulse(sleep_req);
      irc_cycles(10);
   endtask

   initial begin
      int s0, p0, n;

      // R1: reset state
      irc_cycles(4);
      s0 = sys_cnt;
      irc_cycles(4);
      expect_in("R1 flag in reset", 0, 0, pri_stable);
      expect_in("R1 clock stopped in reset", 0, 0, sys_cnt - s0);
      @(negedge irc_clk) rst_n = 1'b1;
      s0 = sys_cnt;
      irc_cycles(6);
      expect_in("R1 idle until start", 0, 0, sys_cnt - s0);

      // R2 / R4 / R5 / R6: power-on, crystal mode
      s0 = sys_cnt;
      @(negedge irc_clk);
      por_evt = 1'b1;
      p0 = pri_cnt;
      @(negedge irc_clk);
      por_evt = 1'b0;
      irc_cycles(19);
      expect_in("R2 runs on RC at once", 16, 20, sys_cnt - s0);
      expect_in("R4 flag clear during count", 0, 0, pri_stable);
      wait_stable(4000);
      expect_in("R4 primary cycles before flag", 1024, 1100, pri_cnt - p0);
      expect_in("R5 flag set while RC low", 0, 0, irc_clk);
      s0 = sys_cnt;
      n = 0;
      while (sys_cnt == s0 && n < 100) begin
         @(negedge pri_clk);
         n++;
      end
      expect_in("R6 hold-low falling edges", 9, 14, n);
      s0 = sys_cnt;
      repeat (200) @(posedge pri_clk);
      expect_in("R6 follows primary", 199, 201, sys_cnt - s0);

      // R8: sleep while on primary
      pulse(sleep_req);
      irc_cycles(4);
      expect_in("R8 flag cleared by sleep", 0, 0, pri_stable);
      s0 = sys_cnt;
      irc_cycles(40);
      expect_in("R8 clock stopped in sleep", 0, 0, sys_cnt - s0);

      // R8: abort mid-count, then restart from zero
      pulse(wake_evt);
      irc_cycles(60);
      expect_in("R8 flag clear mid-count", 0, 0, pri_stable);
      pulse(sleep_req);
      irc_cycles(2);
      s0 = sys_cnt;
      irc_cycles(300);
      expect_in("R8 aborted count never sets flag", 0, 0, pri_stable);
      expect_in("R8 clock stopped after abort", 0, 0, sys_cnt - s0);
      check_full_count("R8 restart counts full");
      irc_cycles(20);

      // R9: non-primary select keeps RC running
      go_sleep();
      sw_clk_sel = 2'b10;
      pulse(wake_evt);
      irc_cycles(400);
      expect_in("R9 flag withheld on RC select", 0, 0, pri_stable);
      s0 = sys_cnt;
      irc_cycles(20);
      expect_in("R9 RC clocking continues", 18, 20, sys_cnt - s0);
      sw_clk_sel = 2'b00;
      n = 0;
      while (!pri_stable && n < 50) begin
         @(negedge irc_clk);
         n++;
      end
      expect_in("R9 flag after select returns", 1, 4, n);
      irc_cycles(20);

      // R10: feature disabled by config bit
      go_sleep();
      tsu_enable = 1'b0;
      check_bypass("R10 config off");

      // R3: non-crystal mode code
      go_sleep();
      tsu_enable = 1'b1;
      pri_mode = 3'd5;
      check_bypass("R3 non-crystal mode");

      // R3: low-power crystal code runs full count
      go_sleep();
      pri_mode = 3'd0;
      check_full_count("R3 crystal mode 000 counts");
      irc_cycles(20);

      // R1: reset while running on primary
      @(negedge irc_clk) rst_n = 1'b0;
      irc_cycles(3);
      expect_in("R1 reset clears flag", 0, 0, pri_stable);
      s0 = sys_cnt;
      irc_cycles(10);
      expect_in("R1 reset stops clock", 0, 0, sys_cnt - s0);
      @(negedge irc_clk) rst_n = 1'b1;

      // R7: pulse widths
      expect_in("R7 min high phase ps", 3500, 1000000, min_high_ps);
      expect_in("R7 min low phase ps", 3500, 1000000, min_low_ps);

      wait (act_q.size() == 0);
      #1;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #600000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule